// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the bus-facing slave of a small serial EEPROM with 128 bytes. It runs on a fast system clock and oversamples the two bus lines, SCL and SDA. It finds start and stop conditions and decodes the device-select byte against a fixed type code and three strap inputs. It acknowledges the bytes it accepts and drives SDA only through an open-drain output enable.

In a write transaction, the second byte loads an internal address counter. Each data byte after that goes out on a single-cycle write strobe to an external page buffer, and a stop tells that buffer to start its write cycle. A read transaction streams bytes from an external read port. It starts at the counter value and keeps going for as long as the master acknowledges. While the external write cycle reports busy, the slave does not answer its own address.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset, sda_oe, wr_en and wr_commit are low and the slave is idle. Only a start (SDA falling while SCL is high) ends idle, so bytes clocked without a preceding start get no acknowledge.
- R2: The select byte arrives MSB first. Bits 7..4 must be 1010, bits 3..1 must equal strap_i[2:0] (bit 3 compared with strap_i[2]), and bit 0 selects read (1) or write (0).
- R3: On a match, sda_oe goes high after the SCL falling edge that ends the eighth bit and stays high until the falling edge that ends the ninth clock.
- R4: On a mismatch, the slave sends no acknowledge and keeps sda_oe low for the rest of the transaction, up to the next start.
- R5: A matching select byte that completes while wr_busy is high is handled as a mismatch.
- R6: In write mode, the slave acknowledges the second byte, and bits 6..0 of that byte load the address counter. Bit 7 is ignored.
- R7: The slave acknowledges each later write byte. Each one gives a single-cycle wr_en with wr_addr equal to the counter and wr_data equal to the byte. The counter then advances, and 127 wraps to 0.
- R8: A stop (SDA rising while SCL is high) gives a single-cycle wr_commit pulse when at least one data byte was accepted since the previous stop. Otherwise it gives no pulse.
- R9: In read mode, the slave sends rd_data for rd_addr (the counter) MSB first. It pulls SDA low for a 0 bit and releases it for a 1 bit. The counter advances once per byte sent, wraps from 127 to 0, and a read starts from its current value (0 after reset).
- R10: If the master acknowledges (SDA low in the ninth clock), the next byte follows. If the master does not, the slave releases SDA and stays silent until the next start.
- R11: A start in the middle of a transaction, even in the middle of a byte, drops the partial byte without writing it and restarts select-byte reception. The counter keeps its value, so a repeated-start read follows the word address just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Strap bits compared with select-byte bits 3..1 |
| wr_busy | input | 1 | Write cycle of the page buffer in progress |
| wr_en | output | 1 | Single-cycle strobe for an accepted data byte |
| wr_addr | output | 7 | Byte address for wr_data |
| wr_data | output | 8 | Accepted data byte |
| wr_commit | output | 1 | Single-cycle pulse on a stop after written data |
| rd_addr | output | 7 | Address counter used as the read address |
| rd_data | input | 8 | Byte at rd_addr, valid one cycle after rd_addr |

## Verification
Most faults inside this block first appear on the bus line, within about three system clocks after an SCL falling edge. A wrong bit count or a misplaced state moves the acknowledge slot or corrupts the read byte that the master samples in the next SCL high phase. A counter that loads, advances or wraps wrongly appears as a wrong wr_addr on the next data byte, or as wrong read data on the next byte sent. A lost transaction flag shows up only at the following stop, as a missing or extra wr_commit.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } bus_st_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_p;
    scl_fall = ~scl_s & scl_p;
    start_ev = scl_s & scl_p & sda_p & ~sda_s;
    stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  end

  // R1
  event_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  // R7
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && (cnt == '1)) |=> (cnt == '0));
  // R6
  ctr_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int          ADDR_W    = 7,
  parameter int          SYNC_STG  = 2,
  parameter logic [3:0]  TYPE_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              wr_busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  import tw_eeprom_pkg::*;

  localparam int BYTE_W = 8;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic [1:0] lines_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] shreg;
  logic [3:0] bitcnt;
  bus_st_t st;
  phase_t ph;
  logic rd_mode, mst_ack, got_data;
  logic byte_done, dev_match, ctr_load, ctr_inc, tx_load;
  logic [ADDR_W-1:0] cnt;

  tw_line_sync #(.STAGES(SYNC_STG), .LINES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  tw_bus_events u_ev (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  always_comb begin
    byte_done = (st == ST_RX) && scl_fall && (bitcnt == LAST_BIT);
    dev_match = (shreg[7:4] == TYPE_CODE) && (shreg[3:1] == strap_i) && !wr_busy;
    tx_load   = scl_fall && (((st == ST_RXACK) && rd_mode) ||
                             ((st == ST_TXACK) && mst_ack));
    ctr_load  = byte_done && (ph == PH_WORD) && !start_ev && !stop_ev;
    ctr_inc   = ((byte_done && (ph == PH_DATA)) || tx_load) && !start_ev && !stop_ev;
  end

  tw_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_val(shreg[ADDR_W-1:0]),
    .inc(ctr_inc), .cnt(cnt));
  assign rd_addr = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_DEV;
      shreg     <= '0;
      bitcnt    <= '0;
      rd_mode   <= 1'b0;
      mst_ack   <= 1'b0;
      got_data  <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      wr_commit <= 1'b0;
      if (start_ev) begin
        st     <= ST_RX;
        ph     <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        wr_commit <= got_data;
        got_data  <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && (bitcnt != LAST_BIT)) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              case (ph)
                PH_DEV: begin
                  if (dev_match) begin
                    rd_mode <= shreg[0];
                    ph      <= PH_WORD;
                    sda_oe  <= 1'b1;
                    st      <= ST_RXACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_WORD: begin
                  ph     <= PH_DATA;
                  sda_oe <= 1'b1;
                  st     <= ST_RXACK;
                end
                default: begin
                  wr_en    <= 1'b1;
                  wr_addr  <= cnt;
                  wr_data  <= shreg;
                  got_data <= 1'b1;
                  sda_oe   <= 1'b1;
                  st       <= ST_RXACK;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST_BIT - 4'd1) begin
                sda_oe <= 1'b0;
                st     <= ST_TXACK;
              end else begin
                sda_oe <= ~shreg[BYTE_W-2];
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mst_ack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                st     <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
  // R5
  busy_noack_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && (ph == PH_DEV) && wr_busy && !start_ev && !stop_ev) |=> !sda_oe);
  // R7
  wr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (sda_oe && (st == ST_RXACK)));
  // R8
  commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (!wr_en && (st == ST_IDLE)));
  // R10
  nack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_TXACK) && scl_fall && !mst_ack && !start_ev && !stop_ev)
      |=> (!sda_oe && (st == ST_IDLE)));
  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= LAST_BIT);
endmodule

// File: tb/tw_eeprom_slave_tb_top.sv
module tw_eeprom_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, wr_commit, wr_busy = 1'b0;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [2:0] strap = 3'b101;
  wire sda_line = sda_m & ~sda_oe;

  tw_eeprom_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .wr_busy(wr_busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data));

  logic [7:0] mem [128];
  logic [7:0] model [128];
  logic [14:0] wq [$];
  int checks = 0, fails = 0, commits = 0, ptr = 0;
  bit quiet = 1'b0, done = 1'b0;

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (wq.size() == 0) chk(1'b0, "R7", "unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [14:0] e;
          e = wq.pop_front();
          chk({wr_addr, wr_data} == e, "R7", "write addr/data", {wr_addr, wr_data}, e);
        end
        mem[wr_addr] = wr_data;
      end
      if (wr_commit) commits++;
      if (quiet && sda_oe) chk(1'b0, "R4", "sda_oe while silent", 1, 0);
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_cyc(input logic b, output logic seen);
    scl_m = 1'b0; wt(5); sda_m = b; wt(5);
    scl_m = 1'b1; wt(4); seen = sda_line; wt(4);
  endtask

  task automatic do_start();
    scl_m = 1'b0; wt(6); sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(4); sda_m = 1'b0; wt(6);
  endtask

  task automatic do_stop(input int exp_commit, input string req);
    int c0;
    c0 = commits;
    scl_m = 1'b0; wt(5); sda_m = 1'b0; wt(5);
    scl_m = 1'b1; wt(5); sda_m = 1'b1; wt(10);
    chk(commits - c0 == exp_commit, req, "commit pulses", commits - c0, exp_commit);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
    bit_cyc(1'b1, s);
    chk(s == !exp_ack, req, "ack slot line", s, !exp_ack);
  endtask

  task automatic read_byte(input bit m_ack, input string req);
    logic s;
    logic [7:0] got;
    logic [7:0] e;
    e = model[ptr];
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1, s);
      got[i] = s;
    end
    ptr = (ptr + 1) % 128;
    bit_cyc(!m_ack, s);
    chk(got == e, req, "read byte", got, e);
  endtask

  task automatic write_data(input logic [7:0] d);
    wq.push_back({7'(ptr), d});
    model[ptr] = d;
    ptr = (ptr + 1) % 128;
    send_byte(d, 1'b1, "R7");
  endtask

  initial begin
    logic s;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    wt(4); rst = 1'b0; wt(2);
    chk(!sda_oe && !wr_en && !wr_commit, "R1", "reset outputs",
        {sda_oe, wr_en, wr_commit}, 0);
    chk(rd_addr == 0, "R9", "counter after reset", rd_addr, 0);

    // R1: bytes without a start are ignored
    quiet = 1'b1;
    send_byte(8'hAA, 1'b0, "R1");
    send_byte(8'h00, 1'b0, "R1");
    quiet = 1'b0;
    chk(wq.size() == 0 && commits == 0, "R1", "no activity before start", commits, 0);

    // R2 R3 R6 R7 R8: write with bit 7 of word address set
    do_start();
    send_byte(8'hAA, 1'b1, "R3");
    send_byte(8'h85, 1'b1, "R6");
    ptr = 5;
    write_data(8'h11); write_data(8'h22); write_data(8'h33);
    do_stop(1, "R8");
    chk(rd_addr == 7'(ptr), "R7", "counter after writes", rd_addr, ptr);

    // R7 wrap on write, then R9/R10 read wrap with ack, nack
    do_start();
    send_byte(8'hAA, 1'b1, "R2");
    send_byte(8'h7F, 1'b1, "R6");
    ptr = 127;
    write_data(8'h44);
    do_stop(1, "R8");
    chk(rd_addr == 0, "R7", "counter wrap on write", rd_addr, 0);
    do_start();
    send_byte(8'hAA, 1'b1, "R6");
    send_byte(8'h7E, 1'b1, "R6");
    ptr = 126;
    do_stop(0, "R8");
    do_start();
    send_byte(8'hAB, 1'b1, "R2");
    read_byte(1'b1, "R9");
    read_byte(1'b1, "R9");
    read_byte(1'b0, "R10");
    quiet = 1'b1;
    bit_cyc(1'b1, s); chk(s == 1'b1, "R10", "released after nack", s, 1);
    bit_cyc(1'b1, s); chk(s == 1'b1, "R10", "released after nack", s, 1);
    quiet = 1'b0;
    do_stop(0, "R8");
    chk(rd_addr == 7'(ptr), "R9", "counter after read wrap", rd_addr, ptr);

    // R9: current-address read
    do_start();
    send_byte(8'hAB, 1'b1, "R9");
    read_byte(1'b0, "R9");
    do_stop(0, "R9");

    // R4 R2: strap and type mismatches
    quiet = 1'b1;
    do_start();
    send_byte(8'hA2, 1'b0, "R4");
    send_byte(8'h00, 1'b0, "R4");
    do_stop(0, "R4");
    do_start();
    send_byte(8'hBA, 1'b0, "R2");
    send_byte(8'h11, 1'b0, "R4");
    do_stop(0, "R4");

    // R5: busy withholds the acknowledge
    wr_busy = 1'b1;
    do_start();
    send_byte(8'hAA, 1'b0, "R5");
    send_byte(8'h10, 1'b0, "R5");
    do_stop(0, "R5");
    wr_busy = 1'b0;
    quiet = 1'b0;

    // R11: repeated start after word address
    do_start();
    send_byte(8'hAA, 1'b1, "R11");
    send_byte(8'h10, 1'b1, "R11");
    ptr = 16;
    do_start();
    send_byte(8'hAB, 1'b1, "R11");
    read_byte(1'b0, "R11");
    do_stop(0, "R11");

    // R11: start in the middle of a data byte
    do_start();
    send_byte(8'hAA, 1'b1, "R11");
    send_byte(8'h20, 1'b1, "R11");
    ptr = 32;
    bit_cyc(1'b1, s); bit_cyc(1'b0, s); bit_cyc(1'b1, s);
    do_start();
    send_byte(8'hAB, 1'b1, "R11");
    read_byte(1'b0, "R11");
    do_stop(0, "R11");
    chk(wq.size() == 0, "R7", "pending expected writes", wq.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule